// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block chooses which of six maskable interrupt requests an 8-bit processor core takes next. Every source carries a 2-bit software level set by the core, and a fixed rank given by its index. The controller keeps the core's current level. A request can only be taken when its level is strictly above the current level. Among the requests that qualify, the highest software level wins, and the source rank breaks a tie.

When the core enters a handler, it pulses an entry strobe. The controller then saves the current level on a small internal stack and loads a new level. In nesting mode the new level is the level of the serviced source, so a request at a higher level can still preempt the handler. In concurrent mode the new level is the masked level 3, so nothing preempts the handler until it returns. The return strobe pops the saved level. A separate strobe lets the main program write the level directly.

The controller also produces the wake signal for the two low-power states. In the light sleep state, any qualifying request wakes the core. In the deep sleep state, only sources in a capability mask can wake it. The same mask limits the arbitration while deep sleep is held and up to the first handler entry after it.

Top module: `nest_irq_ctl`

## Requirements
- R1: After reset, `cur_lvl` is 3 and `irq_take` is 0.
- R2: A request is eligible only when its 2-bit level (numeric 0..3, with 3 the highest) is strictly greater than `cur_lvl`. Requests at or below the current level stay pending and are not taken.
- R3: Among eligible requests, the highest level wins. On equal levels, the higher source index wins (index 5 is the top rank, index 0 the lowest). `irq_vec` carries the winning index and is 0 when `irq_take` is 0. `irq_take`, `irq_vec` and `wake` follow the inputs within the same cycle.
- R4: In nesting mode (`nest_en`=1), an entry strobe while `irq_take` is 1 pushes the current level and loads the winner's level at the next clock edge. A later request at a higher level is then offered while the handler runs.
- R5: In concurrent mode (`nest_en`=0), an entry loads level 3, so `irq_take` stays 0 until a return.
- R6: A return strobe restores the level saved by the matching entry at the next edge. When an entry and a return coincide, the return is ignored.
- R7: A level-write strobe with no entry or return in the same cycle loads `lvl_set_val` into `cur_lvl` at the next edge.
- R8: While `wait_st` is 1, `wake` is 1 exactly when some request is eligible.
- R9: While `halt_st` is 1, `wake` is 1 exactly when some eligible request belongs to `HALT_CAP` (default 6'b110001: sources 0, 4 and 5).
- R10: While `halt_st` is 1, and after it until the first handler entry, only `HALT_CAP` sources can win. Afterwards arbitration is unrestricted, so a higher non-capable request is offered next.
- R11: The level stack holds 4 entries. A fifth push overwrites the oldest slot with no error indication, so the fifth pop returns the overwriting value.
- R12: An entry strobe while `irq_take` is 0 leaves `cur_lvl` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Request lines, bit i is source i |
| irq_lvl | input | 2*NSRC | Software level of source i in bits [2i+1:2i] |
| nest_en | input | 1 | 1 = nesting mode, 0 = concurrent mode |
| wait_st | input | 1 | Core is in light sleep |
| halt_st | input | 1 | Core is in deep sleep |
| enter_ack | input | 1 | Core enters the handler of `irq_vec` |
| exit_ret | input | 1 | Core returns from a handler |
| lvl_set | input | 1 | Main program writes the current level |
| lvl_set_val | input | 2 | Level to write |
| irq_take | output | 1 | A request is ready to be taken |
| irq_vec | output | $clog2(NSRC) | Index of the winning source |
| wake | output | 1 | Leave the low-power state |
| cur_lvl | output | 2 | Current core level |

## Verification
Arbitration and wake are combinational from the inputs and the registered level, so they are due in the cycle their inputs are applied. The bench drives its inputs 1 ns after a rising edge and samples 1 ns later, before the next edge. Level changes from entry, return and level-write strobes are due one edge later, and the bench samples them 1 ns after that edge. The deep-sleep restriction is checked across edges: deep sleep is held over one edge, the bench checks the capable winner, then it checks that the non-capable request is offered after the entry edge.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int LVL_W = 2;
    typedef logic [LVL_W-1:0] lvl_t;
    // level at which every maskable request is held off
    localparam lvl_t LVL_MASKED = 2'd3;
endpackage

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NSRC = 6
) (
    input  logic [NSRC-1:0]       req,
    input  logic [NSRC*LVL_W-1:0] src_lvl,
    input  lvl_t                  cur,
    input  logic [NSRC-1:0]       sel_mask,
    output logic [NSRC-1:0]       elig,
    output logic                  win_vld,
    output logic [$clog2(NSRC)-1:0] win_idx,
    output lvl_t                  win_lvl
);
    localparam int IW = $clog2(NSRC);

    lvl_t lvl_a [NSRC];

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign lvl_a[g] = src_lvl[g*LVL_W +: LVL_W];
        assign elig[g]  = req[g] && (lvl_a[g] > cur);
    end

    // ascending scan with >= lets the higher index win on a level tie
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && sel_mask[i] && (!win_vld || lvl_a[i] >= win_lvl)) begin
                win_vld = 1'b1;
                win_idx = IW'(i);
                win_lvl = lvl_a[i];
            end
        end
    end
endmodule

// File: rtl/nic_wake.sv
module nic_wake #(
    parameter int               NSRC     = 6,
    parameter logic [NSRC-1:0]  HALT_CAP = 6'b110001
) (
    input  logic [NSRC-1:0] elig,
    input  logic            wait_st,
    input  logic            halt_st,
    output logic            wake
);
    logic any_elig;
    logic any_cap;

    always_comb begin
        any_elig = |elig;
        any_cap  = |(elig & HALT_CAP);
        wake     = (wait_st && any_elig) || (halt_st && any_cap);
    end
endmodule

// File: rtl/nic_lvl_stack.sv
module nic_lvl_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  logic set,
    input  lvl_t push_lvl,
    input  lvl_t set_lvl,
    output lvl_t cur_lvl
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        lvl_t [DEPTH-1:0] slot;
        logic [PW-1:0]    sp;
        lvl_t             cur;
    } stk_t;

    stk_t st_d, st_q;
    logic [PW-1:0] sp_inc, sp_dec;

    always_comb begin
        st_d   = st_q;
        sp_inc = (st_q.sp == PW'(DEPTH-1)) ? '0 : st_q.sp + 1'b1;
        sp_dec = (st_q.sp == '0) ? PW'(DEPTH-1) : st_q.sp - 1'b1;
        if (push) begin
            st_d.slot[st_q.sp] = st_q.cur;
            st_d.sp            = sp_inc;
            st_d.cur           = push_lvl;
        end else if (pop) begin
            st_d.sp  = sp_dec;
            st_d.cur = st_q.slot[sp_dec];
        end else if (set) begin
            st_d.cur = set_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sp  <= '0;
            st_q.cur <= LVL_MASKED;
            for (int k = 0; k < DEPTH; k++) st_q.slot[k] <= LVL_MASKED;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_lvl = st_q.cur;

    a_r4_push_loads: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> cur_lvl == $past(push_lvl));
    a_r6_pop_restores: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(push) && pop && !push) |=> cur_lvl == $past(cur_lvl, 2));
    a_r7_set_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !push && !pop) |=> cur_lvl == $past(set_lvl));
endmodule

// File: rtl/nest_irq_ctl.sv
module nest_irq_ctl
    import nic_pkg::*;
#(
    parameter int              NSRC        = 6,
    parameter int              STACK_DEPTH = 4,
    parameter logic [NSRC-1:0] HALT_CAP    = 6'b110001
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          irq_req,
    input  logic [2*NSRC-1:0]        irq_lvl,
    input  logic                     nest_en,
    input  logic                     wait_st,
    input  logic                     halt_st,
    input  logic                     enter_ack,
    input  logic                     exit_ret,
    input  logic                     lvl_set,
    input  logic [1:0]               lvl_set_val,
    output logic                     irq_take,
    output logic [$clog2(NSRC)-1:0]  irq_vec,
    output logic                     wake,
    output logic [1:0]               cur_lvl
);
    typedef struct packed {
        logic post_halt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NSRC-1:0] elig, sel_mask;
    logic            win_vld, take_fire, do_pop;
    logic [$clog2(NSRC)-1:0] win_idx;
    lvl_t            win_lvl, push_lvl, cur_q;

    always_comb begin
        sel_mask  = (halt_st || ctl_q.post_halt) ? HALT_CAP : '1;
        take_fire = enter_ack && win_vld;
        do_pop    = exit_ret && !take_fire;
        push_lvl  = nest_en ? win_lvl : LVL_MASKED;
        ctl_d     = ctl_q;
        if (halt_st)        ctl_d.post_halt = 1'b1;
        else if (take_fire) ctl_d.post_halt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    nic_arbiter #(.NSRC(NSRC)) u_arb (
        .req      (irq_req),
        .src_lvl  (irq_lvl),
        .cur      (cur_q),
        .sel_mask (sel_mask),
        .elig     (elig),
        .win_vld  (win_vld),
        .win_idx  (win_idx),
        .win_lvl  (win_lvl)
    );

    nic_wake #(.NSRC(NSRC), .HALT_CAP(HALT_CAP)) u_wake (
        .elig    (elig),
        .wait_st (wait_st),
        .halt_st (halt_st),
        .wake    (wake)
    );

    nic_lvl_stack #(.DEPTH(STACK_DEPTH)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take_fire),
        .pop      (do_pop),
        .set      (lvl_set),
        .push_lvl (push_lvl),
        .set_lvl  (lvl_set_val),
        .cur_lvl  (cur_q)
    );

    assign irq_take = win_vld;
    assign irq_vec  = win_idx;
    assign cur_lvl  = cur_q;

    a_r2_take_above: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (irq_req[irq_vec] && (irq_lvl[irq_vec*2 +: 2] > cur_lvl)));
    a_r5_conc_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_ack && irq_take && !nest_en) |=> !irq_take);
    a_r9_halt_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_st && !wait_st && wake) |-> |(irq_req & HALT_CAP));
    a_r10_first_capable: assert property (@(posedge clk) disable iff (!rst_n)
        ((halt_st || ctl_q.post_halt) && irq_take) |-> HALT_CAP[irq_vec]);
    a_r12_no_take_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_ack && !irq_take && !exit_ret && !lvl_set) |=> $stable(cur_lvl));
endmodule

// File: tb/nest_irq_ctl_bench.sv
`timescale 1ns/1ps
module nest_irq_ctl_bench;
    localparam int NSRC = 6;
    localparam int NV   = 13;
    localparam int VW   = 27;

    // {cur, wait, halt, req[5:0], lvl{s5..s0}, exp_take, exp_vec, exp_wake}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0,1'b0,1'b0,6'b000001,12'b000000000001,1'b1,3'd0,1'b0}, // R2 R3 single
        {2'd0,1'b0,1'b0,6'b000011,12'b000000001001,1'b1,3'd1,1'b0}, // R3 level wins
        {2'd0,1'b0,1'b0,6'b100010,12'b010000000100,1'b1,3'd5,1'b0}, // R3 tie rank
        {2'd0,1'b0,1'b0,6'b100010,12'b010000001000,1'b1,3'd1,1'b0}, // R3 level over rank
        {2'd2,1'b0,1'b0,6'b000110,12'b000000011000,1'b0,3'd0,1'b0}, // R2 not above
        {2'd1,1'b0,1'b0,6'b000110,12'b000000011000,1'b1,3'd1,1'b0}, // R2 partial
        {2'd0,1'b1,1'b0,6'b000100,12'b000000010000,1'b1,3'd2,1'b1}, // R8 wake
        {2'd2,1'b1,1'b0,6'b000100,12'b000000010000,1'b0,3'd0,1'b0}, // R8 no wake
        {2'd0,1'b0,1'b1,6'b000110,12'b000000111000,1'b0,3'd0,1'b0}, // R9 R10 none capable
        {2'd0,1'b0,1'b1,6'b010010,12'b000100001100,1'b1,3'd4,1'b1}, // R9 R10 capable
        {2'd1,1'b0,1'b1,6'b010000,12'b000100000000,1'b0,3'd0,1'b0}, // R9 capable not above
        {2'd3,1'b0,1'b0,6'b111111,12'b111111111111,1'b0,3'd0,1'b0}, // R2 masked
        {2'd2,1'b0,1'b0,6'b111111,12'b111111111111,1'b1,3'd5,1'b0}  // R3 all tie
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0]   irq_req = '0;
    logic [2*NSRC-1:0] irq_lvl = '0;
    logic nest_en = 1'b1, wait_st = 1'b0, halt_st = 1'b0;
    logic enter_ack = 1'b0, exit_ret = 1'b0, lvl_set = 1'b0;
    logic [1:0] lvl_set_val = '0;
    logic irq_take, wake;
    logic [2:0] irq_vec;
    logic [1:0] cur_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    nest_irq_ctl u_nest_irq_ctl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .nest_en(nest_en), .wait_st(wait_st), .halt_st(halt_st),
        .enter_ack(enter_ack), .exit_ret(exit_ret), .lvl_set(lvl_set),
        .lvl_set_val(lvl_set_val), .irq_take(irq_take), .irq_vec(irq_vec),
        .wake(wake), .cur_lvl(cur_lvl)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_level(input logic [1:0] v);
        lvl_set = 1'b1; lvl_set_val = v;
        step();
        lvl_set = 1'b0;
    endtask

    task automatic idle();
        irq_req = '0; irq_lvl = '0; wait_st = 1'b0; halt_st = 1'b0;
        enter_ack = 1'b0; exit_ret = 1'b0; lvl_set = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        irq_req = 6'b000001; irq_lvl = 12'hFFF;
        #1;
        chk("R1 reset level", cur_lvl, 3);
        chk("R1 reset take", irq_take, 0);
        idle();

        // table walk: combinational arbitration and wake
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            set_level(v[26:25]);
            wait_st = v[24]; halt_st = v[23];
            irq_req = v[22:17]; irq_lvl = v[16:5];
            #1;
            chk($sformatf("R3 vec%0d take", i), irq_take, v[4]);
            chk($sformatf("R3 vec%0d index", i), irq_vec, v[3:1]);
            chk($sformatf("R8/R9 vec%0d wake", i), wake, v[0]);
            idle();
        end

        // R7 level write
        set_level(2'd1);
        chk("R7 level write", cur_lvl, 1);

        // R4 nesting entry, preemption, R6 return
        nest_en = 1'b1;
        set_level(2'd0);
        irq_req = 6'b000010; irq_lvl = 12'b000000000100;
        enter_ack = 1'b1; step(); enter_ack = 1'b0;
        chk("R4 entry loads level", cur_lvl, 1);
        irq_req = 6'b001010; irq_lvl = 12'b000010000100;
        #1;
        chk("R4 preempt take", irq_take, 1);
        chk("R4 preempt index", irq_vec, 3);
        enter_ack = 1'b1; step(); enter_ack = 1'b0;
        chk("R4 nested level", cur_lvl, 2);
        irq_req = '0;
        exit_ret = 1'b1; step();
        chk("R6 first return", cur_lvl, 1);
        step(); exit_ret = 1'b0;
        chk("R6 second return", cur_lvl, 0);

        // R5 concurrent mode
        nest_en = 1'b0;
        irq_req = 6'b000100; irq_lvl = 12'b000000010000;
        enter_ack = 1'b1; step(); enter_ack = 1'b0;
        chk("R5 entry masks", cur_lvl, 3);
        irq_req = 6'b100000; irq_lvl = 12'b100000000000;
        #1;
        chk("R5 no preempt", irq_take, 0);
        exit_ret = 1'b1; step(); exit_ret = 1'b0;
        chk("R5 return level", cur_lvl, 0);
        chk("R5 take after return", irq_take, 1);
        chk("R5 index after return", irq_vec, 5);
        idle();
        nest_en = 1'b1;

        // R6 entry and return together
        irq_req = 6'b000001; irq_lvl = 12'b000000000010;
        enter_ack = 1'b1; exit_ret = 1'b1; step();
        enter_ack = 1'b0; exit_ret = 1'b0;
        chk("R6 return ignored on entry", cur_lvl, 2);
        irq_req = '0;
        exit_ret = 1'b1; step(); exit_ret = 1'b0;
        chk("R6 return after", cur_lvl, 0);

        // R12 entry without take
        set_level(2'd2);
        irq_req = 6'b000001; irq_lvl = 12'b000000000001;
        enter_ack = 1'b1; step(); enter_ack = 1'b0;
        chk("R12 level kept", cur_lvl, 2);
        idle();

        // R10 servicing order after deep sleep
        set_level(2'd0);
        irq_req = 6'b000011; irq_lvl = 12'b000000001101;
        halt_st = 1'b1; step(); halt_st = 1'b0;
        #1;
        chk("R10 capable first take", irq_take, 1);
        chk("R10 capable first index", irq_vec, 0);
        enter_ack = 1'b1; step(); enter_ack = 1'b0;
        chk("R10 level after first", cur_lvl, 1);
        irq_req = 6'b000010;
        #1;
        chk("R10 non-capable next", irq_vec, 1);
        chk("R10 non-capable take", irq_take, 1);
        enter_ack = 1'b1; step(); enter_ack = 1'b0;
        chk("R10 second level", cur_lvl, 3);
        irq_req = '0;
        exit_ret = 1'b1; step(); step(); exit_ret = 1'b0;
        chk("R10 back to main", cur_lvl, 0);
        idle();

        // R11 stack wrap: saved 0,1,2,0,1; pops give 1,0,2,1,1
        irq_req = 6'b100000; irq_lvl = 12'b110000000000;
        for (int k = 0; k < 5; k++) begin
            set_level(2'((k == 3) ? 0 : (k % 3)));
            enter_ack = 1'b1; step(); enter_ack = 1'b0;
        end
        chk("R11 top after pushes", cur_lvl, 3);
        irq_req = '0;
        exit_ret = 1'b1;
        step(); chk("R11 pop1", cur_lvl, 1);
        step(); chk("R11 pop2", cur_lvl, 0);
        step(); chk("R11 pop3", cur_lvl, 2);
        step(); chk("R11 pop4", cur_lvl, 1);
        step(); chk("R11 pop5 overwritten", cur_lvl, 1);
        exit_ret = 1'b0;
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule